// File: doc/BRIEF.md
# Calendar Alarm Match Unit

This block holds two programmable alarms and compares them against the live BCD time of a real-time clock. The first alarm can watch seconds, minutes, hours and a day/date field. The second alarm can watch minutes, hours and a day/date field, and it is only evaluated when the seconds count is 00. Each alarm byte carries its own compare enable in bit 7. A match sets a sticky flag. Software clears that flag by writing zero to its bit. A combined interrupt line reports any flag whose interrupt enable is set.

The timekeeping counters sit outside this block. They present the current seconds, minutes, hours, day-of-week and date together with a one-cycle `tick` strobe, and the fields already hold the new time during the tick cycle. Software reaches the alarm bytes, the control byte and the status byte through a plain single-cycle register port. Writes take effect at the clock edge. Reads are combinational from the address. The block has no streaming data path, so every pin is plain control or status and there is no valid/ready handshake or back-pressure.

Top module: `rtc_alarm_match`

## Requirements
- R1: After reset every alarm byte reads 80h (field disabled), the control byte (address 10h) and status byte (address 11h) read 00h, and `irq` is 0.
- R2: The alarm bytes can be written and read back at these addresses: first alarm seconds 0Ch, minutes 0Dh, hours 0Eh, day/date 0Fh; second alarm minutes 12h, hours 13h, day/date 14h. Control is at 10h (bit 0 enables the first alarm's interrupt, bit 1 the second's). Unmapped addresses read 00h.
- R3: On a tick, the first alarm matches when every byte with bit 7 = 0 equals the current time. Seconds and minutes are compared on bits 6:0. A byte with bit 7 = 1 is ignored, so with all bytes disabled the first alarm matches on every tick.
- R4: In a day/date byte, bit 6 = 1 compares bits 5:0 with the day-of-week input, and bit 6 = 0 compares bits 5:0 with the date input.
- R5: Hours are compared on bits 5:0 only; bit 6 of the hour byte has no effect on the match.
- R6: The second alarm is evaluated only on a tick whose seconds input is 00. With all three of its bytes disabled it matches once per minute.
- R7: Without a tick no flag is set, even when the time equals the alarm.
- R8: The status byte shows the first alarm's flag in bit 0 and the second alarm's flag in bit 1. Flags stay set until software writes 0 to that bit; writing 1 leaves the bit unchanged.
- R9: If a clearing write and a new match for the same flag fall on the same cycle, the flag ends up set.
- R10: `irq` is high exactly while (status bit 0 and control bit 0) or (status bit 1 and control bit 1).
- R11: A flag and `irq` change in the cycle after the tick or write that causes the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle strobe when the time fields take a new value |
| cur_sec | input | 8 | Current seconds, BCD |
| cur_min | input | 8 | Current minutes, BCD |
| cur_hour | input | 8 | Current hours, 24-hour BCD in bits 5:0 |
| cur_dow | input | 8 | Current day of week, 1 to 7 |
| cur_date | input | 8 | Current day of month, BCD |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from `reg_addr` |
| irq | output | 1 | Combined alarm interrupt |

## Verification
Register writes, flag sets and flag clears all land at the clock edge that samples them. So the read data and `irq` are due one cycle after the stimulus, and `reg_rdata` also follows `reg_addr` within the same cycle. The bench changes inputs shortly after a rising edge. Its behavioural model updates on that same rising edge, and every output is compared with the model on the following falling edge, once per clock. Each phase of the stimulus labels its comparisons with the requirement it exercises, including same-cycle clear-and-match, ticks with seconds other than 00, and matching time without a tick.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;

  localparam int unsigned BYTE_W = 8;

  localparam int unsigned ADR_A1_SEC  = 'h0C;
  localparam int unsigned ADR_A1_MIN  = 'h0D;
  localparam int unsigned ADR_A1_HOUR = 'h0E;
  localparam int unsigned ADR_A1_DAY  = 'h0F;
  localparam int unsigned ADR_CTRL    = 'h10;
  localparam int unsigned ADR_STAT    = 'h11;
  localparam int unsigned ADR_A2_MIN  = 'h12;
  localparam int unsigned ADR_A2_HOUR = 'h13;
  localparam int unsigned ADR_A2_DAY  = 'h14;

  localparam logic [BYTE_W-1:0] OFF_BYTE  = 8'h80;
  localparam logic [BYTE_W-1:0] MASK_SM   = 8'h7F;
  localparam logic [BYTE_W-1:0] MASK_HD   = 8'h3F;

  typedef struct packed {
    logic [BYTE_W-1:0] sec;
    logic [BYTE_W-1:0] min;
    logic [BYTE_W-1:0] hour;
    logic [BYTE_W-1:0] day;
  } alarm_cfg_t;

  // bit 7 set means the byte takes no part in the match
  function automatic logic byte_ok(input logic [BYTE_W-1:0] cfg,
                                   input logic [BYTE_W-1:0] now,
                                   input logic [BYTE_W-1:0] mask);
    return cfg[BYTE_W-1] | ((cfg & mask) == (now & mask));
  endfunction

endpackage

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp
  import rtc_alarm_pkg::*;
#(
  parameter bit HAS_SEC = 1'b1
) (
  input  alarm_cfg_t        cfg,
  input  logic [BYTE_W-1:0] cur_sec,
  input  logic [BYTE_W-1:0] cur_min,
  input  logic [BYTE_W-1:0] cur_hour,
  input  logic [BYTE_W-1:0] cur_dow,
  input  logic [BYTE_W-1:0] cur_date,
  output logic              hit
);

  logic              sec_ok;
  logic [BYTE_W-1:0] day_src;

  generate
    if (HAS_SEC) begin : g_sec
      assign sec_ok = byte_ok(cfg.sec, cur_sec, MASK_SM);
    end else begin : g_top_of_min
      assign sec_ok = ((cur_sec & MASK_SM) == '0);
    end
  endgenerate

  assign day_src = cfg.day[6] ? cur_dow : cur_date;

  assign hit = sec_ok
             & byte_ok(cfg.min,  cur_min,  MASK_SM)
             & byte_ok(cfg.hour, cur_hour, MASK_HD)
             & byte_ok(cfg.day,  day_src,  MASK_HD);

endmodule

// File: rtl/rtc_alarm_flag.sv
module rtc_alarm_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);

  always_ff @(posedge clk) begin
    if (!rst_n)   flag <= 1'b0;
    else if (set) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end

  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr) |=> flag);

  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set) |=> !flag);

  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> flag);

endmodule

// File: rtl/rtc_alarm_regs.sv
module rtc_alarm_regs
  import rtc_alarm_pkg::*;
#(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned N_ALM  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  output alarm_cfg_t        cfg [N_ALM],
  output logic [N_ALM-1:0]  irq_en
);

  alarm_cfg_t       a1_q, a2_q;
  logic [N_ALM-1:0] en_q;

  function automatic logic hit_at(input logic [ADDR_W-1:0] a, input int unsigned target);
    return (32'(a) == target);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a1_q <= '{sec: OFF_BYTE, min: OFF_BYTE, hour: OFF_BYTE, day: OFF_BYTE};
      a2_q <= '{sec: OFF_BYTE, min: OFF_BYTE, hour: OFF_BYTE, day: OFF_BYTE};
      en_q <= '0;
    end else if (we) begin
      if (hit_at(addr, ADR_A1_SEC))  a1_q.sec  <= wdata;
      if (hit_at(addr, ADR_A1_MIN))  a1_q.min  <= wdata;
      if (hit_at(addr, ADR_A1_HOUR)) a1_q.hour <= wdata;
      if (hit_at(addr, ADR_A1_DAY))  a1_q.day  <= wdata;
      if (hit_at(addr, ADR_A2_MIN))  a2_q.min  <= wdata;
      if (hit_at(addr, ADR_A2_HOUR)) a2_q.hour <= wdata;
      if (hit_at(addr, ADR_A2_DAY))  a2_q.day  <= wdata;
      if (hit_at(addr, ADR_CTRL))    en_q      <= wdata[N_ALM-1:0];
    end
  end

  always_comb begin
    cfg[0]     = a1_q;
    cfg[1]     = a2_q;
    cfg[1].sec = OFF_BYTE;
  end

  assign irq_en = en_q;

endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
  import rtc_alarm_pkg::*;
#(
  parameter int unsigned ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [7:0]        cur_sec,
  input  logic [7:0]        cur_min,
  input  logic [7:0]        cur_hour,
  input  logic [7:0]        cur_dow,
  input  logic [7:0]        cur_date,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              irq
);

  localparam int unsigned N_ALM = 2;

  alarm_cfg_t       cfg [N_ALM];
  logic [N_ALM-1:0] irq_en;
  logic [N_ALM-1:0] hit, flag, clr;
  logic             stat_wr;

  rtc_alarm_regs #(.ADDR_W(ADDR_W), .N_ALM(N_ALM)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
    .wdata(reg_wdata), .cfg(cfg), .irq_en(irq_en)
  );

  assign stat_wr = reg_we && (32'(reg_addr) == ADR_STAT);

  generate
    for (genvar i = 0; i < N_ALM; i++) begin : g_alm
      rtc_alarm_cmp #(.HAS_SEC(i == 0)) u_cmp (
        .cfg(cfg[i]), .cur_sec(cur_sec), .cur_min(cur_min),
        .cur_hour(cur_hour), .cur_dow(cur_dow), .cur_date(cur_date),
        .hit(hit[i])
      );
      assign clr[i] = stat_wr && !reg_wdata[i];
      rtc_alarm_flag u_flag (
        .clk(clk), .rst_n(rst_n), .set(tick && hit[i]),
        .clr(clr[i]), .flag(flag[i])
      );
    end
  endgenerate

  assign irq = |(flag & irq_en);

  always_comb begin
    case (32'(reg_addr))
      ADR_A1_SEC:  reg_rdata = cfg[0].sec;
      ADR_A1_MIN:  reg_rdata = cfg[0].min;
      ADR_A1_HOUR: reg_rdata = cfg[0].hour;
      ADR_A1_DAY:  reg_rdata = cfg[0].day;
      ADR_CTRL:    reg_rdata = {{(BYTE_W-N_ALM){1'b0}}, irq_en};
      ADR_STAT:    reg_rdata = {{(BYTE_W-N_ALM){1'b0}}, flag};
      ADR_A2_MIN:  reg_rdata = cfg[1].min;
      ADR_A2_HOUR: reg_rdata = cfg[1].hour;
      ADR_A2_DAY:  reg_rdata = cfg[1].day;
      default:     reg_rdata = '0;
    endcase
  end

  a_r7_no_set_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && (flag == '0)) |=> (flag == '0));

  a_r6_a2_top_of_minute: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !flag[1] && (cur_sec[6:0] != 7'd0)) |=> !flag[1]);

  a_r10_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (flag == '0) |-> !irq);

endmodule

// File: tb/rtc_alarm_match_test.sv
`timescale 1ns/1ps
module rtc_alarm_match_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic [7:0] cur_sec = 8'h00, cur_min = 8'h00, cur_hour = 8'h00;
  logic [7:0] cur_dow = 8'h01, cur_date = 8'h01;
  logic       reg_we = 1'b0;
  logic [4:0] reg_addr = 5'h00;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       irq;

  int n_checks = 0;
  int n_fail = 0;
  string tag = "R1";

  always #2.5 clk = ~clk;

  rtc_alarm_match uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cur_sec(cur_sec),
    .cur_min(cur_min), .cur_hour(cur_hour), .cur_dow(cur_dow),
    .cur_date(cur_date), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  // behavioural reference model
  int m_a1 [4];
  int m_a2 [3];
  int m_ctrl, m_f1, m_f2;

  function automatic bit fld(int a, int c, int m);
    return ((a & 128) != 0) || ((a & m) == (c & m));
  endfunction

  function automatic int model_read(int a);
    case (a)
      12: return m_a1[0];
      13: return m_a1[1];
      14: return m_a1[2];
      15: return m_a1[3];
      16: return m_ctrl;
      17: return m_f1 + 2 * m_f2;
      18: return m_a2[0];
      19: return m_a2[1];
      20: return m_a2[2];
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_a1[i]) m_a1[i] = 128;
      foreach (m_a2[i]) m_a2[i] = 128;
      m_ctrl = 0; m_f1 = 0; m_f2 = 0;
    end else begin
      bit h1, h2;
      int dsel1, dsel2;
      dsel1 = ((m_a1[3] & 64) != 0) ? int'(cur_dow) : int'(cur_date);
      dsel2 = ((m_a2[2] & 64) != 0) ? int'(cur_dow) : int'(cur_date);
      h1 = tick && fld(m_a1[0], cur_sec, 127) && fld(m_a1[1], cur_min, 127)
                && fld(m_a1[2], cur_hour, 63) && fld(m_a1[3], dsel1, 63);
      h2 = tick && ((cur_sec & 127) == 0) && fld(m_a2[0], cur_min, 127)
                && fld(m_a2[1], cur_hour, 63) && fld(m_a2[2], dsel2, 63);
      if (reg_we) begin
        case (int'(reg_addr))
          12: m_a1[0] = reg_wdata;
          13: m_a1[1] = reg_wdata;
          14: m_a1[2] = reg_wdata;
          15: m_a1[3] = reg_wdata;
          16: m_ctrl = reg_wdata & 3;
          17: begin
            if (!reg_wdata[0]) m_f1 = 0;
            if (!reg_wdata[1]) m_f2 = 0;
          end
          18: m_a2[0] = reg_wdata;
          19: m_a2[1] = reg_wdata;
          20: m_a2[2] = reg_wdata;
          default: ;
        endcase
      end
      if (h1) m_f1 = 1;
      if (h2) m_f2 = 1;
    end
  end

  task automatic check(string req, int act, int exp, string what);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // every clock: compare all outputs against the model
  always @(negedge clk) begin
    if (rst_n) begin
      check(tag, int'(reg_rdata), model_read(int'(reg_addr)), "rdata");
      check((tag == "R10") ? "R10" : tag, int'(irq),
            ((m_f1 & m_ctrl) | (m_f2 & (m_ctrl >> 1))) & 1, "irq");
    end
  end

  task automatic step(int n = 1);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic wr(int a, int d);
    reg_we = 1'b1; reg_addr = 5'(a); reg_wdata = 8'(d);
    step();
    reg_we = 1'b0; reg_addr = 5'h11;
  endtask

  task automatic rd(int a);
    reg_addr = 5'(a);
    step();
  endtask

  task automatic set_time(int s, int m, int h, int dw, int dt);
    cur_sec = 8'(s); cur_min = 8'(m); cur_hour = 8'(h);
    cur_dow = 8'(dw); cur_date = 8'(dt);
  endtask

  task automatic pulse();
    tick = 1'b1;
    step();
    tick = 1'b0;
    reg_addr = 5'h11;
    step();
  endtask

  initial begin
    #(200000 * 5);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    // R1: reset state across the map
    tag = "R1";
    for (int a = 10; a < 23; a++) rd(a);
    check("R1", int'(irq), 0, "irq after reset");

    // R2: register write and read-back
    tag = "R2";
    wr(12, 8'h45); wr(13, 8'h12); wr(14, 8'h07); wr(15, 8'h23);
    wr(18, 8'h59); wr(19, 8'h23); wr(20, 8'h31); wr(16, 8'h03);
    for (int a = 10; a < 23; a++) rd(a);

    // R3: first alarm seconds and minutes enabled, rest disabled
    tag = "R3";
    wr(12, 8'h30); wr(13, 8'h15); wr(14, 8'h80); wr(15, 8'h80);
    wr(18, 8'h80 | 8'h10); wr(19, 8'h80); wr(20, 8'h80);
    set_time(8'h30, 8'h16, 8'h09, 3, 8'h05); pulse();
    check("R3", int'(reg_rdata), 0, "mismatched minute sets nothing");
    set_time(8'h30, 8'h15, 8'h09, 3, 8'h05); pulse();
    check("R3", int'(reg_rdata), 1, "status after match");

    // R7: matching time without tick
    tag = "R7";
    wr(17, 0);
    step(5);
    check("R7", int'(reg_rdata), 0, "no set without tick");

    // R4: day-of-week versus date selection
    tag = "R4";
    wr(12, 8'h80); wr(13, 8'h80); wr(15, 8'h42);
    set_time(8'h01, 8'h00, 8'h00, 3, 8'h02); pulse();
    set_time(8'h02, 8'h00, 8'h00, 2, 8'h09); pulse();
    wr(17, 0);
    wr(15, 8'h02);
    set_time(8'h03, 8'h00, 8'h00, 2, 8'h09); pulse();
    set_time(8'h04, 8'h00, 8'h00, 5, 8'h02); pulse();
    wr(17, 0);

    // R5: hour compare ignores bit 6
    tag = "R5";
    wr(15, 8'h80); wr(14, 8'h52);
    set_time(8'h05, 8'h00, 8'h12, 1, 1); pulse();
    set_time(8'h06, 8'h00, 8'h13, 1, 1); wr(17, 0); pulse();
    wr(14, 8'h80);

    // R6: second alarm every minute when all disabled, only at second 00
    tag = "R6";
    wr(12, 8'h59); wr(18, 8'h80);
    set_time(8'h01, 8'h10, 8'h10, 1, 1); pulse();
    set_time(8'h00, 8'h11, 8'h10, 1, 1); pulse();
    wr(17, 0);
    wr(18, 8'h20); wr(19, 8'h20); wr(20, 8'h01);
    set_time(8'h00, 8'h20, 8'h20, 4, 8'h01); pulse();
    set_time(8'h00, 8'h21, 8'h20, 4, 8'h01); wr(17, 0); pulse();

    // R8: writing 1 keeps, writing 0 clears only that bit
    tag = "R8";
    wr(12, 8'h80); wr(18, 8'h80); wr(19, 8'h80); wr(20, 8'h80);
    set_time(8'h00, 8'h30, 8'h01, 1, 1); pulse();
    wr(17, 8'h03); step(2);
    wr(17, 8'h02); step(2);
    wr(17, 8'h00); step(2);

    // R9: clear and new match in the same cycle
    tag = "R9";
    set_time(8'h00, 8'h31, 8'h01, 1, 1); pulse();
    reg_we = 1'b1; reg_addr = 5'h11; reg_wdata = 8'h00; tick = 1'b1;
    step();
    reg_we = 1'b0; tick = 1'b0;
    step();
    check("R9", int'(reg_rdata), 3, "set wins over clear");

    // R10 / R11: interrupt gating and latency
    tag = "R10";
    wr(16, 8'h00); step(2);
    wr(16, 8'h02); step(2);
    wr(17, 8'h01); step(2);
    wr(16, 8'h01); step(2);
    wr(17, 8'h00); step(2);
    tag = "R11";
    set_time(8'h00, 8'h40, 8'h02, 1, 1);
    tick = 1'b1; step(); tick = 1'b0;
    check("R11", int'(irq), 1, "irq one cycle after tick");
    step(2);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule